// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block is a purely combinational binary adder. It takes two operands and a carry-in and returns the sum, the carry-out, and the group generate and group propagate for the whole operand width. A wide datapath can use these to chain or nest the adder inside a larger lookahead structure.

Every bit position first forms its own generate and propagate terms. Four-input lookahead units merge these terms, four at a time, into group terms. Each layer of units feeds the next, until a single node covers the whole word. The carry-in then enters at the root. Every unit turns the carry into its group into carries for its four children, so the carries pass back down the tree to each bit. Each sum bit is its propagate term XORed with the carry into that position.

The number of logic levels grows with the base-4 logarithm of the width, not linearly. The width parameter accepts 16, which gives two lookahead layers, or 64, which gives three. Any other value stops elaboration.

Top module: `cla_adder_tree`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^WIDTH, for WIDTH of 16 and of 64.
- R2: `carry_out` equals bit WIDTH of the full-precision sum `op_a` + `op_b` + `carry_in`.
- R3: `grp_prop` is 1 exactly when every bit position has `op_a[i]` different from `op_b[i]`, whatever `carry_in` is.
- R4: `grp_gen` is 1 exactly when `op_a` + `op_b` with a zero carry-in reaches 2^WIDTH, whatever `carry_in` is.
- R5: `carry_out` equals `grp_gen` OR (`grp_prop` AND `carry_in`).
- R6: the carry into each bit i equals bit i of the sum of the low i bits of both operands plus `carry_in`, so that `sum[i]` = `op_a[i]` XOR `op_b[i]` XOR that carry.
- R7: when every position propagates, the carry-in passes the full width. `carry_out` then equals `carry_in`, and `sum` is all ones when `carry_in` is 0 and all zeros when `carry_in` is 1.
- R8: with both operands zero and `carry_in` 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |
| grp_gen | output | 1 | Whole-word generate |
| grp_prop | output | 1 | Whole-word propagate |

## Verification
The hardest case is a carry that must cross every group boundary at every layer. This only happens when all bit positions propagate, and random operands almost never produce that. Directed vectors therefore build it: one operand paired with its complement, with the carry-in at 0 and at 1. Other directed vectors create a single generate at bit 0 below a long propagating run, which pushes a carry from the lowest leaf up to the root and back down to the top bit. Random operands at both widths cover the mixed cases in between.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Number of radix-4 layers needed to reduce w bits to one node.
  function automatic int tree_levels(input int w);
    int n;
    int lv;
    n  = w;
    lv = 0;
    while (n > 1) begin
      n  = n / 4;
      lv = lv + 1;
    end
    return lv;
  endfunction

  // Start index of layer l in the flat node vector (layer 0 = bits).
  function automatic int layer_offset(input int w, input int l);
    int s;
    s = 0;
    for (int m = 0; m < l; m++) s = s + (w >> (2 * m));
    return s;
  endfunction

  // Total node count over all layers, root included.
  function automatic int node_total(input int w);
    return layer_offset(w, tree_levels(w) + 1);
  endfunction

  // Merge four child generate/propagate pairs: returns {G, P}.
  function automatic logic [1:0] merge_quad(input logic [3:0] g, input logic [3:0] p);
    logic gg;
    logic pp;
    gg = g[3]
       | (g[2] & p[3])
       | (g[1] & p[2] & p[3])
       | (g[0] & p[1] & p[2] & p[3]);
    pp = &p;
    return {gg, pp};
  endfunction

  // Carries into children 1..3 given the carry into child 0.
  function automatic logic [2:0] split_carry(input logic [3:0] g, input logic [3:0] p,
                                             input logic ci);
    logic c1;
    logic c2;
    logic c3;
    c1 = g[0] | (ci & p[0]);
    c2 = g[1] | (g[0] & p[1]) | (ci & p[0] & p[1]);
    c3 = g[2] | (g[1] & p[2]) | (g[0] & p[1] & p[2]) | (ci & p[0] & p[1] & p[2]);
    return {c3, c2, c1};
  endfunction

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] bit_gen,
  output logic [WIDTH-1:0] bit_prop
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_gen[i]  = op_a[i] & op_b[i];
    assign bit_prop[i] = op_a[i] ^ op_b[i];
  end
endmodule

// File: rtl/cla_quad_unit.sv
module cla_quad_unit (
  input  logic [3:0] kid_gen,
  input  logic [3:0] kid_prop,
  input  logic       grp_cin,
  output logic       grp_gen,
  output logic       grp_prop,
  output logic [2:0] kid_cin_hi
);
  logic [1:0] merged;
  assign merged     = cla_pkg::merge_quad(kid_gen, kid_prop);
  assign grp_gen    = merged[1];
  assign grp_prop   = merged[0];
  assign kid_cin_hi = cla_pkg::split_carry(kid_gen, kid_prop, grp_cin);
endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] bit_prop,
  input  logic [WIDTH-1:0] bit_cin,
  output logic [WIDTH-1:0] sum
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum[i] = bit_prop[i] ^ bit_cin[i];
  end
endmodule

// File: rtl/cla_adder_tree.sv
module cla_adder_tree #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             grp_gen,
  output logic             grp_prop
);
  localparam int LEVELS = cla_pkg::tree_levels(WIDTH);
  localparam int NODES  = cla_pkg::node_total(WIDTH);
  localparam int ROOT   = NODES - 1;

  if (!(WIDTH == 16 || WIDTH == 64)) begin : g_bad_width
    $error("cla_adder_tree: WIDTH must be 16 or 64");
  end

  // Flat node store: layer 0 holds bits, layer LEVELS holds the root.
  logic [NODES-1:0] node_gen;
  logic [NODES-1:0] node_prop;
  logic [NODES-1:0] node_cin;

  // Named internal wire for the checker: carry into every bit.
  logic [WIDTH-1:0] carry_into_bit;

  cla_bit_cell #(.WIDTH(WIDTH)) u_bits (
    .op_a     (op_a),
    .op_b     (op_b),
    .bit_gen  (node_gen[WIDTH-1:0]),
    .bit_prop (node_prop[WIDTH-1:0])
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_layer
    localparam int CHILD_OFF  = cla_pkg::layer_offset(WIDTH, l);
    localparam int PARENT_OFF = cla_pkg::layer_offset(WIDTH, l + 1);
    localparam int UNITS      = WIDTH >> (2 * (l + 1));
    for (genvar k = 0; k < UNITS; k++) begin : g_unit
      localparam int CB = CHILD_OFF + 4 * k;
      localparam int PB = PARENT_OFF + k;
      cla_quad_unit u_quad (
        .kid_gen    (node_gen[CB+3:CB]),
        .kid_prop   (node_prop[CB+3:CB]),
        .grp_cin    (node_cin[PB]),
        .grp_gen    (node_gen[PB]),
        .grp_prop   (node_prop[PB]),
        .kid_cin_hi (node_cin[CB+3:CB+1])
      );
      // The lowest child shares its parent's carry-in.
      assign node_cin[CB] = node_cin[PB];
    end
  end

  assign node_cin[ROOT]  = carry_in;
  assign grp_gen         = node_gen[ROOT];
  assign grp_prop        = node_prop[ROOT];
  assign carry_into_bit  = node_cin[WIDTH-1:0];

  cla_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .bit_prop (node_prop[WIDTH-1:0]),
    .bit_cin  (carry_into_bit),
    .sum      (sum)
  );

  assign carry_out = grp_gen | (grp_prop & carry_in);

endmodule

// File: rtl/cla_adder_tree_chk.sv
module cla_adder_tree_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic             grp_gen,
  input logic             grp_prop,
  input logic [WIDTH-1:0] carry_into_bit
);
  logic [WIDTH:0] full_add;
  logic [WIDTH:0] bare_add;
  logic           known;

  assign full_add = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
  assign bare_add = {1'b0, op_a} + {1'b0, op_b};
  assign known    = !$isunknown({op_a, op_b, carry_in});

  always_comb begin
    if (known) begin
      AST_SUM_VALUE: assert (sum == full_add[WIDTH-1:0]); // R1
      AST_CARRY_OUT: assert (carry_out == full_add[WIDTH]); // R2
      AST_GROUP_PROP: assert (grp_prop == ((op_a ^ op_b) == {WIDTH{1'b1}})); // R3
      AST_GROUP_GEN: assert (grp_gen == bare_add[WIDTH]); // R4
      AST_FULL_RUN: assert (!grp_prop || (carry_out == carry_in)); // R7
    end
  end

  always_comb begin
    logic [WIDTH-1:0] m;
    logic [WIDTH:0]   low;
    if (known) begin
      for (int i = 0; i < WIDTH; i++) begin
        m   = (WIDTH'(1) << i) - WIDTH'(1);
        low = {1'b0, op_a & m} + {1'b0, op_b & m} + {{WIDTH{1'b0}}, carry_in};
        AST_BIT_CARRY: assert (carry_into_bit[i] == low[i]); // R6
      end
    end
  end
endmodule

bind cla_adder_tree cla_adder_tree_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a           (op_a),
  .op_b           (op_b),
  .carry_in       (carry_in),
  .sum            (sum),
  .carry_out      (carry_out),
  .grp_gen        (grp_gen),
  .grp_prop       (grp_prop),
  .carry_into_bit (carry_into_bit)
);

// File: tb/cla_adder_tree_test.sv
`timescale 1ns/1ps
module cla_adder_tree_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16, gg16, gp16;
  logic [63:0] a64 = '0, b64 = '0, s64;
  logic        c64 = 1'b0, co64, gg64, gp64;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  cla_adder_tree #(.WIDTH(16)) uut (
    .op_a(a16), .op_b(b16), .carry_in(c16),
    .sum(s16), .carry_out(co16), .grp_gen(gg16), .grp_prop(gp16)
  );

  cla_adder_tree #(.WIDTH(64)) uut_w (
    .op_a(a64), .op_b(b64), .carry_in(c64),
    .sum(s64), .carry_out(co64), .grp_gen(gg64), .grp_prop(gp64)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] width_mask(input int w);
    return (w == 64) ? {64{1'b1}} : 64'h0000_0000_0000_FFFF;
  endfunction

  // Carry into each bit, found from sums of low slices.
  function automatic logic [63:0] bit_carries(input int w, input logic [63:0] a,
                                              input logic [63:0] b, input logic ci);
    logic [63:0] r;
    logic [64:0] low;
    logic [63:0] m;
    r = '0;
    for (int i = 0; i < w; i++) begin
      m    = (i == 0) ? 64'd0 : ({64{1'b1}} >> (64 - i));
      low  = {1'b0, a & m} + {1'b0, b & m} + {64'd0, ci};
      r[i] = low[i];
    end
    return r;
  endfunction

  task automatic run_vec(input int w, input logic [63:0] a, input logic [63:0] b,
                         input logic ci);
    logic [63:0] m;
    logic [64:0] full;
    logic [64:0] bare;
    logic [63:0] act_s;
    logic        act_co, act_g, act_p, e_prop;
    m = width_mask(w);
    @(posedge clk);
    if (w == 64) begin a64 = a; b64 = b; c64 = ci; end
    else begin a16 = a[15:0]; b16 = b[15:0]; c16 = ci; end
    @(negedge clk);
    if (w == 64) begin act_s = s64; act_co = co64; act_g = gg64; act_p = gp64; end
    else begin act_s = {48'd0, s16}; act_co = co16; act_g = gg16; act_p = gp16; end
    full   = {1'b0, a & m} + {1'b0, b & m} + {64'd0, ci};
    bare   = {1'b0, a & m} + {1'b0, b & m};
    e_prop = (((a ^ b) & m) == m);
    chk("R1 sum", act_s, full[63:0] & m);
    chk("R2 carry_out", {63'd0, act_co}, {63'd0, full[w]});
    chk("R3 grp_prop", {63'd0, act_p}, {63'd0, e_prop});
    chk("R4 grp_gen", {63'd0, act_g}, {63'd0, bare[w]});
    chk("R5 carry_out vs group", {63'd0, act_co}, {63'd0, bare[w] | (e_prop & ci)});
    chk("R6 per-bit carry", act_s, (a ^ b ^ bit_carries(w, a, b, ci)) & m);
    if (e_prop) begin
      chk("R7 full run sum", act_s, ci ? 64'd0 : m);
      chk("R7 full run carry", {63'd0, act_co}, {63'd0, ci});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R8: all-zero inputs give all-zero outputs
    @(negedge clk);
    chk("R8 zero sum16", {48'd0, s16}, 64'd0);
    chk("R8 zero flags16", {61'd0, co16, gg16, gp16}, 64'd0);
    chk("R8 zero sum64", s64, 64'd0);
    chk("R8 zero flags64", {61'd0, co64, gg64, gp64}, 64'd0);

    for (int wi = 0; wi < 2; wi++) begin
      automatic int w = (wi == 0) ? 16 : 64;
      automatic logic [63:0] m = width_mask(w);
      run_vec(w, 64'd0, 64'd0, 1'b0);
      run_vec(w, 64'd0, 64'd0, 1'b1);
      run_vec(w, m, m, 1'b1);                       // all ones with carry-in
      run_vec(w, 64'h5555_5555_5555_5555 & m, 64'hAAAA_AAAA_AAAA_AAAA & m, 1'b0); // R7
      run_vec(w, 64'h5555_5555_5555_5555 & m, 64'hAAAA_AAAA_AAAA_AAAA & m, 1'b1); // R7
      run_vec(w, 64'h5555_5555_5555_5555 & m, 64'h5555_5555_5555_5555 & m, 1'b1);
      run_vec(w, m, 64'd1, 1'b0);                   // leaf generate to top bit
      run_vec(w, m - 64'd1, 64'd1, 1'b1);
      run_vec(w, 64'h0123_4567_89AB_CDEF & m, ~64'h0123_4567_89AB_CDEF & m, 1'b1); // R7
      for (int k = 0; k < 300; k++) begin
        automatic logic [63:0] ra = {$urandom, $urandom};
        automatic logic [63:0] rb = {$urandom, $urandom};
        automatic logic rc = 1'($urandom);
        if (k % 10 == 0) rb = ~ra;                  // R7 forced full propagate
        run_vec(w, ra & m, rb & m, rc);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule